// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Interlock

This block is the control skeleton of an in-order pipeline with four stages: fetch, decode, execute and commit. It carries no operand values. Each instruction is reduced to a tag, up to two source register indices and up to two destination register indices, and each slot has its own enable bit. The block moves these descriptors through the stages and keeps a record of which registers an in-flight instruction will still write.

Sources are read in decode and results are written in commit. There is no forwarding, so an instruction in decode that reads a register still owed by an older instruction stays in decode. Fetch stays with it, a bubble goes into execute, and the older instructions keep moving. The hold ends in the cycle in which the producing instruction commits, because the write lands early in that cycle. An instruction may write two registers at once, for example a load that also increments its base pointer. A later reader of either register waits.

The block reports which stages are occupied, when it stalls, and a commit pulse that carries the committing instruction's tag. A surrounding model uses these outputs to drive a real datapath or to measure the cost of dependences.

Top module: `pipe_interlock`

## Requirements
- R1: A synchronous reset empties all four stages and clears every pending-write record. After reset, `occ` is 0, `stall` is 0, `commit_valid` is 0 and `in_ready` is 1. An instruction whose producer was flushed by reset does not wait.
- R2: With no dependences, one instruction is accepted per cycle. Each instruction shows on `commit_valid`/`commit_tag` exactly four rising edges after the edge that accepted it, and consecutive instructions commit on consecutive cycles.
- R3: Every accepted instruction that is not flushed by reset commits exactly once, and instructions commit in the order they were accepted.
- R4: When the instruction in decode reads a register that the immediately older instruction writes through destination slot 0, `stall` is 1 and `in_ready` is 0 for one cycle. The consumer commits five edges after its acceptance edge.
- R5: A register written through destination slot 1 blocks a reader exactly as slot 0 does, and both registers of a two-destination instruction are tracked.
- R6: During a stall, the next cycle has execute empty while the producer moves to commit and the consumer stays in decode. `occ` bit 0 is fetch, bit 1 is decode, bit 2 is execute and bit 3 is commit.
- R7: A hold ends in the cycle the producer commits. A consumer two instructions behind its producer is never stalled and commits four edges after acceptance.
- R8: A source or destination slot whose enable bit is 0 is ignored. Its index value creates no dependence.
- R9: All 16 register indices are tracked alike, including index 0 and index 15.
- R10: When several in-flight instructions write the same register, a reader waits until the youngest of them commits.
- R11: `in_ready` equals the inverse of `stall`. An idle input cycle (`in_valid` 0) places a bubble in fetch that moves on like an instruction and produces no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered to fetch |
| in_tag | input | 8 | Tag of the offered instruction |
| in_src0_en | input | 1 | Source slot 0 used |
| in_src0 | input | 4 | Source slot 0 register index |
| in_src1_en | input | 1 | Source slot 1 used |
| in_src1 | input | 4 | Source slot 1 register index |
| in_dst0_en | input | 1 | Destination slot 0 used |
| in_dst0 | input | 4 | Destination slot 0 register index |
| in_dst1_en | input | 1 | Destination slot 1 used |
| in_dst1 | input | 4 | Destination slot 1 register index |
| in_ready | output | 1 | Fetch accepts an instruction this cycle |
| occ | output | 4 | Stage occupancy: bit0 fetch, bit1 decode, bit2 execute, bit3 commit |
| stall | output | 1 | Decode is held this cycle |
| commit_valid | output | 1 | An instruction commits this cycle |
| commit_tag | output | 8 | Tag of the committing instruction |

## Verification
Directed streams are used. A stream with no dependences sets the baseline latency and rate. Adjacent read-after-write pairs through each destination slot show a one-cycle hold and where the bubble goes. A pair two instructions apart shows that the hold ends at the producer's commit and not one cycle later. Other streams cover disabled slots whose indices collide, register 0 and register 15, two in-flight writers of one register (which separates counting from a single busy flag), idle input gaps, and a reset in the middle of a stream. Across all streams, commit order is compared with acceptance order.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  parameter int unsigned NREG     = 16;
  parameter int unsigned REG_W    = $clog2(NREG);
  parameter int unsigned TAG_W    = 8;
  // writers that can be past decode at once: execute and commit
  parameter int unsigned MAX_HOLD = 2;
  parameter int unsigned CNT_W    = $clog2(MAX_HOLD + 1);

  typedef logic [REG_W-1:0] ridx_t;
  typedef logic [NREG-1:0]  rmask_t;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic             s0_en;
    ridx_t            s0;
    logic             s1_en;
    ridx_t            s1;
    logic             d0_en;
    ridx_t            d0;
    logic             d1_en;
    ridx_t            d1;
  } uop_t;

  localparam uop_t UOP_NOP = '0;

  // one-hot register mask of a single slot, empty when the slot is off
  function automatic rmask_t slot_mask(input logic en, input ridx_t idx);
    rmask_t m;
    m = '0;
    if (en) m[idx] = 1'b1;
    return m;
  endfunction

  function automatic rmask_t dst_mask(input uop_t u);
    return u.valid ? (slot_mask(u.d0_en, u.d0) | slot_mask(u.d1_en, u.d1)) : '0;
  endfunction

  function automatic rmask_t src_mask(input uop_t u);
    return u.valid ? (slot_mask(u.s0_en, u.s0) | slot_mask(u.s1_en, u.s1)) : '0;
  endfunction
endpackage

// File: rtl/ilk_pending.sv
module ilk_pending
  import ilk_pkg::*;
#(
  parameter int unsigned N_REG  = NREG,
  parameter int unsigned HOLD_N = MAX_HOLD,
  parameter int unsigned C_W    = CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REG-1:0] set_mask,
  input  logic [N_REG-1:0] clr_mask,
  output logic [N_REG-1:0] held
);
  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic [C_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + C_W'(set_mask[i]) - C_W'(clr_mask[i]);
    end

    // a write landing this cycle no longer blocks a reader
    assign held[i] = (cnt > C_W'(clr_mask[i]));

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
      clr_mask[i] |-> (cnt != '0));
    a_r10_hold_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= C_W'(HOLD_N));
  end
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
(
  input  uop_t   dec,
  input  rmask_t held,
  output rmask_t hit,
  output logic   stall
);
  assign hit   = src_mask(dec) & held;
  assign stall = dec.valid && (hit != '0);
endmodule

// File: rtl/ilk_stages.sv
module ilk_stages
  import ilk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  uop_t in_uop,
  input  logic stall,
  output uop_t f_q,
  output uop_t d_q,
  output uop_t e_q,
  output uop_t c_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      f_q <= UOP_NOP;
      d_q <= UOP_NOP;
      e_q <= UOP_NOP;
      c_q <= UOP_NOP;
    end else begin
      c_q <= e_q;
      e_q <= stall ? UOP_NOP : d_q;
      if (!stall) begin
        d_q <= f_q;
        f_q <= in_uop;
      end
    end
  end

  a_r6_bubble_on_stall: assert property (@(posedge clk) disable iff (rst)
    stall |=> !e_q.valid);
  a_r4_decode_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (d_q == $past(d_q)));
  a_r11_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (f_q == $past(f_q)));
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import ilk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_src0_en,
  input  logic [REG_W-1:0] in_src0,
  input  logic             in_src1_en,
  input  logic [REG_W-1:0] in_src1,
  input  logic             in_dst0_en,
  input  logic [REG_W-1:0] in_dst0,
  input  logic             in_dst1_en,
  input  logic [REG_W-1:0] in_dst1,
  output logic             in_ready,
  output logic [3:0]       occ,
  output logic             stall,
  output logic             commit_valid,
  output logic [TAG_W-1:0] commit_tag
);
  uop_t   in_uop, f_q, d_q, e_q, c_q;
  rmask_t held, hit, issue_set, commit_clr;

  assign in_uop = '{valid: in_valid, tag: in_tag,
                    s0_en: in_src0_en, s0: in_src0,
                    s1_en: in_src1_en, s1: in_src1,
                    d0_en: in_dst0_en, d0: in_dst0,
                    d1_en: in_dst1_en, d1: in_dst1};

  // named events: registers claimed on leaving decode, released on commit
  assign issue_set  = stall ? '0 : dst_mask(d_q);
  assign commit_clr = dst_mask(c_q);

  ilk_stages u_stages (
    .clk(clk), .rst(rst), .in_uop(in_uop), .stall(stall),
    .f_q(f_q), .d_q(d_q), .e_q(e_q), .c_q(c_q)
  );

  ilk_pending #(.N_REG(NREG), .HOLD_N(MAX_HOLD), .C_W(CNT_W)) u_pending (
    .clk(clk), .rst(rst), .set_mask(issue_set), .clr_mask(commit_clr),
    .held(held)
  );

  ilk_hazard u_hazard (
    .dec(d_q), .held(held), .hit(hit), .stall(stall)
  );

  assign in_ready     = !stall;
  assign occ          = {c_q.valid, e_q.valid, d_q.valid, f_q.valid};
  assign commit_valid = c_q.valid;
  assign commit_tag   = c_q.tag;

  // an instruction right behind its producer must not have left decode early
  a_r4_no_raw_overlap: assert property (@(posedge clk) disable iff (rst)
    (e_q.valid && c_q.valid) |-> ((src_mask(e_q) & dst_mask(c_q)) == '0));
  a_r8_hit_needs_source: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |-> d_q.valid);
endmodule

// File: tb/pipe_interlock_tb.sv
module pipe_interlock_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_tag = '0;
  logic       in_src0_en = 1'b0, in_src1_en = 1'b0, in_dst0_en = 1'b0, in_dst1_en = 1'b0;
  logic [3:0] in_src0 = '0, in_src1 = '0, in_dst0 = '0, in_dst1 = '0;
  logic       in_ready, stall, commit_valid;
  logic [3:0] occ;
  logic [7:0] commit_tag;

  pipe_interlock u_dut (.*);

  always #10 clk = ~clk;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int stall_cnt = 0;
  int acc_cyc [256];
  int com_cyc [256];
  int log_tag [256];
  int log_n = 0;
  int next_tag = 1;
  int flushed = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && commit_valid) begin
      com_cyc[commit_tag] = cyc;
      log_tag[log_n] = commit_tag;
      log_n++;
    end
    if (!rst && stall) stall_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // offer one instruction, return its tag once accepted
  task automatic send(input bit s0e, input int s0, input bit s1e, input int s1,
                      input bit d0e, input int d0, input bit d1e, input int d1,
                      output int t);
    t = next_tag;
    next_tag++;
    in_valid = 1'b1; in_tag = 8'(t);
    in_src0_en = s0e; in_src0 = 4'(s0); in_src1_en = s1e; in_src1 = 4'(s1);
    in_dst0_en = d0e; in_dst0 = 4'(d0); in_dst1_en = d1e; in_dst1 = 4'(d1);
    while (!in_ready) @(negedge clk);
    acc_cyc[t] = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  function automatic int lat(input int t);
    return com_cyc[t] - acc_cyc[t];
  endfunction

  task automatic t_reset();
    chk("R1 occ after reset", int'(occ), 0);
    chk("R1 stall after reset", int'(stall), 0);
    chk("R1 commit_valid after reset", int'(commit_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_stream();
    int t [6];
    int s0 = stall_cnt;
    for (int i = 0; i < 6; i++) send(1, 14, 1, 15, 1, i + 1, 0, 0, t[i]);
    drain();
    for (int i = 0; i < 6; i++) chk("R2 independent latency", lat(t[i]), 4);
    for (int i = 0; i < 5; i++) chk("R2 back-to-back commit", com_cyc[t[i+1]] - com_cyc[t[i]], 1);
    chk("R2 no stall in independent stream", stall_cnt - s0, 0);
  endtask

  task automatic t_raw0();
    int p, q;
    int s0 = stall_cnt;
    send(0, 0, 0, 0, 1, 5, 0, 0, p);
    send(1, 5, 0, 0, 0, 0, 0, 0, q);
    drain();
    chk("R4 consumer latency slot0", lat(q), 5);
    chk("R4 one stall cycle", stall_cnt - s0, 1);
    chk("R4 producer latency", lat(p), 4);
  endtask

  task automatic t_raw1();
    int p, q, p2, q2;
    send(0, 0, 0, 0, 1, 7, 1, 8, p);
    send(0, 0, 1, 8, 0, 0, 0, 0, q);
    drain();
    chk("R5 reader of slot1 dest", lat(q), 5);
    send(0, 0, 0, 0, 1, 7, 1, 8, p2);
    send(1, 7, 0, 0, 0, 0, 0, 0, q2);
    drain();
    chk("R5 reader of slot0 of two-dest instr", lat(q2), 5);
  endtask

  task automatic t_bubble();
    int p, q;
    send(0, 0, 0, 0, 1, 4, 0, 0, p);
    send(1, 4, 0, 0, 0, 0, 0, 0, q);
    @(negedge clk);
    chk("R4 stall raised", int'(stall), 1);
    chk("R11 in_ready low in stall", int'(in_ready), 0);
    @(negedge clk);
    chk("R6 bubble in execute occ", int'(occ), 4'b1010);
    chk("R7 stall released at producer commit", int'(stall), 0);
    chk("R6 producer commits", int'(commit_tag), p);
    @(negedge clk);
    chk("R6 consumer moves to execute", int'(occ), 4'b0100);
    drain();
  endtask

  task automatic t_dist2();
    int p, x, q;
    int s0 = stall_cnt;
    send(0, 0, 0, 0, 1, 9, 0, 0, p);
    send(0, 0, 0, 0, 1, 10, 0, 0, x);
    send(1, 9, 0, 0, 0, 0, 0, 0, q);
    drain();
    chk("R7 distance two no stall", stall_cnt - s0, 0);
    chk("R7 distance two latency", lat(q), 4);
  endtask

  task automatic t_enable();
    int p, q, p2, q2;
    int s0 = stall_cnt;
    send(0, 0, 0, 0, 1, 2, 0, 11, p);
    send(1, 11, 0, 0, 0, 0, 0, 0, q);
    send(0, 0, 0, 0, 1, 12, 0, 0, p2);
    send(0, 12, 0, 12, 0, 0, 0, 0, q2);
    drain();
    chk("R8 disabled dest ignored", lat(q), 4);
    chk("R8 disabled sources ignored", lat(q2), 4);
    chk("R8 no stall from disabled slots", stall_cnt - s0, 0);
  endtask

  task automatic t_edges();
    int p, q, p2, q2;
    send(0, 0, 0, 0, 1, 0, 0, 0, p);
    send(0, 0, 1, 0, 0, 0, 0, 0, q);
    drain();
    chk("R9 register 0 tracked", lat(q), 5);
    send(0, 0, 0, 0, 0, 0, 1, 15, p2);
    send(1, 15, 0, 0, 0, 0, 0, 0, q2);
    drain();
    chk("R9 register 15 tracked", lat(q2), 5);
  endtask

  task automatic t_waw();
    int p1, p2, q;
    int s0 = stall_cnt;
    send(0, 0, 0, 0, 1, 3, 0, 0, p1);
    send(0, 0, 0, 0, 1, 3, 0, 0, p2);
    send(1, 3, 0, 0, 0, 0, 0, 0, q);
    drain();
    chk("R10 reader waits for youngest writer", lat(q), 5);
    chk("R10 single stall cycle", stall_cnt - s0, 1);
    chk("R10 writers unaffected", lat(p2), 4);
  endtask

  task automatic t_gap();
    int a, b;
    send(0, 0, 0, 0, 1, 1, 0, 0, a);
    @(negedge clk);
    chk("R11 idle input gives empty fetch", int'(occ[0]), 0);
    @(negedge clk);
    send(0, 0, 0, 0, 1, 2, 0, 0, b);
    drain();
    chk("R11 gap latency a", lat(a), 4);
    chk("R11 gap latency b", lat(b), 4);
    chk("R11 gap spacing", com_cyc[b] - com_cyc[a], 3);
  endtask

  task automatic t_midreset();
    int p, q;
    send(0, 0, 0, 0, 1, 6, 0, 0, p);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    flushed++;
    chk("R1 mid-run reset empties stages", int'(occ), 0);
    send(1, 6, 0, 0, 0, 0, 0, 0, q);
    drain();
    chk("R1 flushed producer never commits", com_cyc[p], -1);
    chk("R1 markers cleared", lat(q), 4);
  endtask

  task automatic t_order();
    chk("R3 commit count", log_n, next_tag - 1 - flushed);
    for (int i = 0; i + 1 < log_n; i++)
      if (log_tag[i] >= log_tag[i+1]) chk("R3 commit order", log_tag[i+1], log_tag[i] + 1);
    chk("R3 order scan done", 1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin acc_cyc[i] = -1; com_cyc[i] = -1; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stream();
    t_raw0();
    t_raw1();
    t_bubble();
    t_dist2();
    t_enable();
    t_edges();
    t_waw();
    t_gap();
    t_midreset();
    t_order();
    summary();
  end
endmodule